// File: doc/BRIEF.md
# Sensor Byte Capture FIFO

This block accepts 8-bit pixel samples from an image sensor's parallel data pins and holds them for a host processor. The write side is clocked by the sensor's pixel clock and takes one byte on every cycle in which the sample strobe is high. The read side is a Wishbone slave clocked by the processor bus clock. The two clocks are unrelated.

Four bytes in a row are packed into one 32-bit word. The first byte of the four lands in bits 7:0. A word enters storage only when its fourth byte has arrived. The store holds 2048 words (8 KB). Pointers cross between the clock domains as Gray code through two-flop synchronisers. Full is judged on the pixel side and empty on the bus side.

The pixel input is a valid-only stream: there is no ready and no back-pressure. The sensor cannot be paused. While the store is full, incoming bytes are dropped and a sticky overflow flag records the loss. Software polls the fill level and drains words through the data register. A control bit starts and stops capture.

Top module: `pix_capture_fifo`

Register map (word index on `wb_adr_i`):

| Index | Register | Contents |
|-------|----------|----------|
| 0 | Data | Read pops one word. Writes are ignored. |
| 1 | Status | Bits 15:0 fill level in words. Bit 16 overflow. Bit 17 underflow. Write 1 to bit 16 or bit 17 to clear that flag. |
| 2 | Control | Bit 0 capture enable (read/write). |
| 3 | Unused | Reads as zero. |

## Requirements
- R1: Bytes are packed little-endian: the first of four consecutive accepted bytes is in bits 7:0 and the fourth is in bits 31:24. Words read from the data register (index 0) come out in arrival order.
- R2: While capture is enabled and the store is not full, a byte is accepted on every pixel clock cycle with `pix_valid` high, with no stall and no gap.
- R3: The store holds 2048 words. Once it is full, further bytes are dropped, and the words already held stay intact. After one word is read, a new word is accepted again.
- R4: A dropped byte sets the overflow flag (status bit 16). The flag stays set until a write to the status register (index 1) carries 1 in bit 16. A write with 0 in bit 16 leaves it set.
- R5: A read of the data register while the store is empty returns zero, is still acknowledged, and sets the underflow flag (status bit 17). Writing 1 to bit 17 clears that flag.
- R6: Every Wishbone access is acknowledged for exactly one cycle. The acknowledge comes in the cycle after `wb_cyc_i` and `wb_stb_i` are first seen together, and never appears without a request.
- R7: Status bits 15:0 report the number of complete words held, as seen in the bus clock domain.
- R8: Control bit 0 (index 2) enables capture. While it is 0, bytes are ignored. Clearing it discards any partly packed word.
- R9: After reset the fill level, both flags, the capture enable and the acknowledge are all zero.
- R10: A partly packed word (one to three bytes) does not count in the fill level and cannot be read.
- R11: The read pointer never passes the write pointer, and the occupancy never exceeds 2048 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Sensor pixel clock |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| pix_valid | input | 1 | Sample strobe; no back-pressure |
| pix_data | input | 8 | Pixel byte, bit 0 to bit 7 |
| wb_clk_i | input | 1 | Bus clock |
| wb_rst_i | input | 1 | Synchronous active-high reset, bus domain |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 2 | Register word index |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
A broken packer would show up on the first data read as bytes in the wrong lane, or as a word that is missing or shifted. A Gray or full-compare fault would show only near the capacity boundary. It would appear either as a fill level that stops short of 2048, or as the oldest words being overwritten when the store is drained after an overflow. A fault in the flag crossing shows in the status register within a few pixel cycles of a drop. Flag and acknowledge faults show on the very next bus access.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_OVF_BIT = 16;
  localparam int unsigned STAT_UDF_BIT = 17;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/pcf_sync.sv
module pcf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pcf_dpram.sv
module pcf_dpram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 32
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcf_wr_side.sv
module pcf_wr_side #(
  parameter int unsigned DEPTH = 2048
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic                     pix_valid,
  input  logic [7:0]               pix_data,
  input  logic [$clog2(DEPTH):0]   rgray_s,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_waddr,
  output logic [31:0]              mem_wdata,
  output logic [$clog2(DEPTH):0]   wgray,
  output logic                     drop_tgl
);
  import pcf_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [1:0]    lane;
  logic [23:0]   hold;
  logic [PW-1:0] wbin;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] used;
  logic          full;
  logic          accept;
  logic          drop;

  assign rbin_s = PW'(gray2bin(32'(rgray_s)));
  assign used   = wbin - rbin_s;
  assign full   = (used == PW'(DEPTH));
  assign accept = cap_en && pix_valid && !full;
  assign drop   = cap_en && pix_valid && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane     <= '0;
      hold     <= '0;
      wbin     <= '0;
      wgray    <= '0;
      drop_tgl <= 1'b0;
    end else begin
      wgray <= PW'(bin2gray(32'(wbin)));
      if (drop) drop_tgl <= ~drop_tgl;
      if (!cap_en) begin
        lane <= '0;
      end else if (accept) begin
        if (lane == 2'd3) begin
          lane <= '0;
          wbin <= wbin + 1'b1;
        end else begin
          hold[8*lane +: 8] <= pix_data;
          lane <= lane + 1'b1;
        end
      end
    end
  end

  assign mem_we    = accept && (lane == 2'd3);
  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = {pix_data, hold};

  a_r11_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
    used <= PW'(DEPTH));

  a_r8_disabled_clears_lane: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> (lane == 2'd0));

  a_r3_no_commit_when_full: assert property (@(posedge clk) disable iff (rst)
    full |=> (wbin == $past(wbin)));
endmodule

// File: rtl/pcf_rd_side.sv
module pcf_rd_side #(
  parameter int unsigned DEPTH = 2048
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cyc,
  input  logic                     stb,
  input  logic                     we,
  input  logic [1:0]               adr,
  input  logic [31:0]              dat_i,
  output logic [31:0]              dat_o,
  output logic                     ack,
  input  logic [$clog2(DEPTH):0]   wgray_s,
  input  logic                     drop_tgl_s,
  input  logic [31:0]              mem_q,
  output logic [$clog2(DEPTH)-1:0] mem_raddr,
  output logic [$clog2(DEPTH):0]   rgray,
  output logic                     cap_en
);
  import pcf_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  reg_sel_e      sel;
  logic [PW-1:0] rbin;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] level;
  logic          empty;
  logic          req;
  logic          tgl_d;
  logic          ovf;
  logic          udf;
  logic          ovf_set;
  logic          stat_wr;
  logic          empty_rd;
  logic [31:0]   status;
  logic          unused_dat_bits;

  assign sel      = reg_sel_e'(adr);
  assign wbin_s   = PW'(gray2bin(32'(wgray_s)));
  assign level    = wbin_s - rbin;
  assign empty    = (level == '0);
  assign req      = cyc && stb && !ack;
  assign ovf_set  = tgl_d ^ drop_tgl_s;
  assign stat_wr  = req && we && (sel == REG_STAT);
  assign empty_rd = req && !we && (sel == REG_DATA) && empty;
  assign status   = {14'd0, udf, ovf, 16'(level)};
  assign mem_raddr = rbin[AW-1:0];
  assign unused_dat_bits = ^{dat_i[31:18], dat_i[15:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ack    <= 1'b0;
      dat_o  <= '0;
      rbin   <= '0;
      rgray  <= '0;
      tgl_d  <= 1'b0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
      cap_en <= 1'b0;
    end else begin
      ack   <= req;
      rgray <= PW'(bin2gray(32'(rbin)));
      tgl_d <= drop_tgl_s;

      if (ovf_set) ovf <= 1'b1;
      else if (stat_wr && dat_i[STAT_OVF_BIT]) ovf <= 1'b0;

      if (empty_rd) udf <= 1'b1;
      else if (stat_wr && dat_i[STAT_UDF_BIT]) udf <= 1'b0;

      if (req) begin
        unique case (sel)
          REG_DATA: begin
            if (!we && !empty) begin
              dat_o <= mem_q;
              rbin  <= rbin + 1'b1;
            end else begin
              dat_o <= '0;
            end
          end
          REG_STAT: dat_o <= status;
          REG_CTRL: begin
            dat_o <= {31'd0, cap_en};
            if (we) cap_en <= dat_i[0];
          end
          default:  dat_o <= '0;
        endcase
      end
    end
  end

  a_r6_ack_single_cycle: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r6_ack_needs_request: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(cyc && stb));

  a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    empty_rd |=> (dat_o == '0) && udf);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(stat_wr && dat_i[STAT_OVF_BIT])) |=> ovf);

  a_r11_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= PW'(DEPTH));
endmodule

// File: rtl/pix_capture_fifo.sv
module pix_capture_fifo #(
  parameter int unsigned DEPTH_WORDS = 2048
) (
  input  logic        pix_clk,
  input  logic        pix_rst,
  input  logic        pix_valid,
  input  logic [7:0]  pix_data,
  input  logic        wb_clk_i,
  input  logic        wb_rst_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [1:0]  wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o
);
  localparam int unsigned AW = $clog2(DEPTH_WORDS);
  localparam int unsigned PW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [31:0]   mem_wdata;
  logic [AW-1:0] mem_raddr;
  logic [31:0]   mem_q;
  logic [PW-1:0] wgray, wgray_s;
  logic [PW-1:0] rgray, rgray_s;
  logic          drop_tgl, drop_tgl_s;
  logic          cap_en_bus, cap_en_pix;

  pcf_wr_side #(.DEPTH(DEPTH_WORDS)) u_wr (
    .clk       (pix_clk),
    .rst       (pix_rst),
    .cap_en    (cap_en_pix),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .rgray_s   (rgray_s),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .wgray     (wgray),
    .drop_tgl  (drop_tgl)
  );

  pcf_sync #(.W(PW)) u_sync_rptr (
    .clk (pix_clk), .rst (pix_rst), .d (rgray), .q (rgray_s)
  );

  pcf_sync #(.W(1)) u_sync_en (
    .clk (pix_clk), .rst (pix_rst), .d (cap_en_bus), .q (cap_en_pix)
  );

  pcf_sync #(.W(PW)) u_sync_wptr (
    .clk (wb_clk_i), .rst (wb_rst_i), .d (wgray), .q (wgray_s)
  );

  pcf_sync #(.W(1)) u_sync_drop (
    .clk (wb_clk_i), .rst (wb_rst_i), .d (drop_tgl), .q (drop_tgl_s)
  );

  pcf_dpram #(.AW(AW), .DW(32)) u_ram (
    .wclk  (pix_clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .rclk  (wb_clk_i),
    .raddr (mem_raddr),
    .rdata (mem_q)
  );

  pcf_rd_side #(.DEPTH(DEPTH_WORDS)) u_rd (
    .clk        (wb_clk_i),
    .rst        (wb_rst_i),
    .cyc        (wb_cyc_i),
    .stb        (wb_stb_i),
    .we         (wb_we_i),
    .adr        (wb_adr_i),
    .dat_i      (wb_dat_i),
    .dat_o      (wb_dat_o),
    .ack        (wb_ack_o),
    .wgray_s    (wgray_s),
    .drop_tgl_s (drop_tgl_s),
    .mem_q      (mem_q),
    .mem_raddr  (mem_raddr),
    .rgray      (rgray),
    .cap_en     (cap_en_bus)
  );
endmodule

// File: tb/test_pix_capture_fifo.sv
`timescale 1ns/1ps
module test_pix_capture_fifo;
  localparam int DEPTH = 2048;

  logic        pix_clk = 1'b0;
  logic        wb_clk  = 1'b0;
  logic        pix_rst = 1'b1;
  logic        wb_rst  = 1'b1;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0]  adr = '0;
  logic [31:0] dat_i = '0;
  logic [31:0] dat_o;
  logic        ack;

  always #4  wb_clk  = ~wb_clk;
  always #21 pix_clk = ~pix_clk;

  pix_capture_fifo #(.DEPTH_WORDS(DEPTH)) i_pix_capture_fifo (
    .pix_clk (pix_clk), .pix_rst (pix_rst), .pix_valid (pix_valid), .pix_data (pix_data),
    .wb_clk_i (wb_clk), .wb_rst_i (wb_rst), .wb_cyc_i (cyc), .wb_stb_i (stb),
    .wb_we_i (we), .wb_adr_i (adr), .wb_dat_i (dat_i), .wb_dat_o (dat_o), .wb_ack_o (ack)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  bit mdl_en = 0, mdl_ovf = 0, mdl_udf = 0;
  int mdl_lane = 0;
  logic [31:0] mdl_word = '0;
  bit mon_arm = 0;
  logic [31:0] rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected words as data reads complete
  always @(negedge wb_clk) begin
    if (mon_arm && ack) begin
      if (exp_q.size() > 0) chk("R1 word order/packing", dat_o, exp_q.pop_front());
      else begin
        chk("R5 empty read returns zero", dat_o, 32'h0);
        mdl_udf = 1;
      end
    end
  end

  task automatic wb_xfer(input logic [1:0] a, input logic w, input logic [31:0] d,
                         output logic [31:0] r);
    int waited;
    @(negedge wb_clk);
    cyc = 1; stb = 1; we = w; adr = a; dat_i = d;
    waited = 0;
    @(negedge wb_clk);
    while (!ack) begin waited++; @(negedge wb_clk); end
    chk("R6 ack latency", 32'(waited), 32'd0);
    r = dat_o;
    cyc = 0; stb = 0; we = 0; dat_i = '0;
    @(negedge wb_clk);
    chk("R6 ack one cycle", {31'd0, ack}, 32'd0);
  endtask

  task automatic read_data();
    logic [31:0] r;
    mon_arm = 1;
    wb_xfer(2'd0, 1'b0, 32'h0, r);
    mon_arm = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge pix_clk);
    repeat (4) @(negedge wb_clk);
  endtask

  task automatic check_status(input string tag);
    logic [31:0] r;
    wb_xfer(2'd1, 1'b0, 32'h0, r);
    chk(tag, r, {14'd0, mdl_udf, mdl_ovf, 16'(exp_q.size())});
  endtask

  task automatic set_en(input bit v);
    logic [31:0] r;
    wb_xfer(2'd2, 1'b1, {31'd0, v}, r);
    mdl_en = v;
    if (!v) mdl_lane = 0;
    settle();
  endtask

  // Driver: streams bytes back to back and updates the expected-word queue
  task automatic push_bytes(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'(seed + k * 13 + (k >> 8));
      @(negedge pix_clk);
      pix_valid = 1; pix_data = b;
      if (mdl_en) begin
        if (exp_q.size() < DEPTH) begin
          mdl_word[8*mdl_lane +: 8] = b;
          mdl_lane++;
          if (mdl_lane == 4) begin exp_q.push_back(mdl_word); mdl_lane = 0; end
        end else mdl_ovf = 1;
      end
    end
    @(negedge pix_clk);
    pix_valid = 0;
    settle();
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge pix_clk);
    pix_rst = 0;
    @(negedge wb_clk);
    wb_rst = 0;
    settle();

    // R9 reset state
    chk("R9 ack idle", {31'd0, ack}, 32'd0);
    check_status("R9 status after reset");
    wb_xfer(2'd2, 1'b0, 32'h0, rd);
    chk("R9 capture enable after reset", rd, 32'h0);

    // R8 bytes ignored while disabled
    push_bytes(8, 8'h40);
    check_status("R8 disabled bytes ignored");

    // R2 / R7 / R1 back-to-back capture
    set_en(1);
    push_bytes(8, 1);
    check_status("R7 level after two words");
    read_data();
    read_data();
    check_status("R7 level after drain");

    // R10 partial word not visible
    push_bytes(3, 8'h90);
    check_status("R10 partial word hidden");
    push_bytes(1, 8'hA0);
    check_status("R10 word committed on fourth byte");
    read_data();

    // R8 clearing discards partial word
    push_bytes(2, 8'h55);
    set_en(0);
    set_en(1);
    push_bytes(4, 8'h21);
    check_status("R8 partial discarded");
    read_data();

    // R5 underflow
    read_data();
    check_status("R5 underflow flag set");
    wb_xfer(2'd1, 1'b1, 32'h0002_0000, rd);
    mdl_udf = 0;
    check_status("R5 underflow cleared");

    // R3 / R4 fill to capacity and beyond
    push_bytes(DEPTH * 4 + 8, 7);
    check_status("R3 full level and overflow");
    wb_xfer(2'd1, 1'b1, 32'h0002_0000, rd);
    check_status("R4 overflow stays without bit16 write");
    wb_xfer(2'd1, 1'b1, 32'h0001_0000, rd);
    mdl_ovf = 0;
    check_status("R4 overflow cleared");
    read_data();
    settle();
    push_bytes(4, 8'hC3);
    check_status("R3 refill after one read");
    for (int i = 0; i < DEPTH; i++) read_data();
    check_status("R7 empty after full drain");
    wb_xfer(2'd0, 1'b1, 32'hDEAD_BEEF, rd);
    check_status("R1 data write ignored");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule